// File: doc/BRIEF.md
# Quad DAC Serial Register Front-End

This block is the digital control core of a four-channel voltage-output converter. A host writes 24-bit frames over a serial port that has a clock, a data input and an active-low frame strobe. Each frame that completes is split into a command, a one-hot channel mask and a 16-bit data word. The block holds two registers per channel. The holding register receives written data. The active register drives that channel's output code. Active registers change on a command or on the load strobe. The load strobe works in two ways: a falling edge copies holding values at any time, and a strobe held low during a write makes that write take effect when its frame ends.

The serial output pin serves two uses through one shift path. In daisy-chain mode it passes the previous frame on to the next device in the chain. In readback it returns one holding register during the frame after the request. Reset, and a software reset command, set every code to zero or to midscale, as picked by a select input. Each channel also has a power-down flag. All serial and strobe inputs are sampled by the system clock, so the serial clock must run several times slower than it.

Top module: `quad_dac_frontend`

## Requirements
- R1: A frame is 24 bits, sent MSB first and sampled on falling edges of `sclk`. It is laid out as command in bits 23:20, channel mask in bits 19:16 (bit 16 is channel 0) and data in bits 15:0. Command 1 writes the data into the holding register of each masked channel and leaves the active codes alone while `upd_n` is high.
- R2: Command 3 writes the data into both the holding and the active register of each masked channel. The active codes change once the strobe has risen.
- R3: Command 2 copies holding into active for the masked channels only.
- R4: A falling edge on `upd_n` copies holding into active for every channel that the load mask does not exclude.
- R5: When `upd_n` is low at the end of a command 1 frame, the written channels that are not excluded by the load mask get the new data in their active registers.
- R6: Command 5 sets the load mask from data bits 3:0. A channel whose bit is 1 ignores `upd_n` in both update modes.
- R7: A frame whose strobe rises before 24 falling clock edges is discarded. It changes no code and no flag.
- R8: While `rst` is high, every holding and active register is set to 0x8000 if `mid_sel` is 1 and to 0 otherwise. All power-down flags, the load mask, daisy-chain mode and readback are cleared, so `sdo_oe` is low.
- R9: Command 6 has the same effect as R8, using the value of `mid_sel` at that time.
- R10: Command 4 sets the power-down flag of each masked channel to data bit 0. Unmasked channels keep their flags.
- R11: Command 8 turns daisy-chain mode on or off according to data bit 0. While it is on, `sdo_oe` is high. `sdo` presents the previous 24-bit frame MSB first, with each bit changing after a rising edge of `sclk`.
- R12: Command 9 selects the lowest-numbered channel in its mask. During the next frame `sdo_oe` is high and `sdo` returns {4'h0, one-hot channel, holding code}. After that frame `sdo_oe` goes low again.
- R13: Command 0 and the unassigned command values (7, 10 to 15) change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mid_sel | input | 1 | Reset level select: 1 = midscale, 0 = zero |
| sclk | input | 1 | Serial clock, idles high |
| fs_n | input | 1 | Active-low frame strobe |
| sdi | input | 1 | Serial data in |
| upd_n | input | 1 | Active-low load strobe |
| code_o | output | 64 | Active codes, channel n in bits 16n+15:16n |
| pd_o | output | 4 | Per-channel power-down flags |
| sdo | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for sdo |

## Verification
On every cycle, the assertions check the per-channel copy rules: an asynchronous load or a synchronous write leaves active equal to the new holding value, holding changes only on a write, and a software reset lands on the selected level. They also check that the bit counter never passes the frame length and that a discarded frame leaves codes and flags untouched. Only the bench scenarios can show the end-to-end serial behaviour. That covers MSB-first decoding of real frames, load-mask exclusion across a sequence of writes, the readback word appearing one frame later, and the daisy-chain output echoing each earlier frame bit for bit.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int CH     = 4;
    localparam int DW     = 16;
    localparam int CMD_W  = 4;
    localparam int FRAME_BITS = CMD_W + CH + DW;
    localparam int CNT_W  = $clog2(FRAME_BITS + 1);

    typedef logic [DW-1:0] code_t;

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP   = 4'd0,
        CMD_WR    = 4'd1,
        CMD_UPD   = 4'd2,
        CMD_WRUPD = 4'd3,
        CMD_PWR   = 4'd4,
        CMD_LMASK = 4'd5,
        CMD_SRST  = 4'd6,
        CMD_CHAIN = 4'd8,
        CMD_RDBK  = 4'd9
    } cmd_e;

    typedef struct packed {
        cmd_e            cmd;
        logic [CH-1:0]   mask;
        code_t           data;
    } frame_t;

    function automatic code_t reset_code(input logic mid);
        return mid ? (code_t'(1) << (DW - 1)) : '0;
    endfunction
endpackage

// File: rtl/dacfe_sync.sv
module dacfe_sync #(
    parameter int W = 2,
    parameter logic [W-1:0] RV = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] din,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] s1, s2;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= RV;
            s2 <= RV;
        end else begin
            s1 <= din;
            s2 <= s1;
        end
    end

    assign rise = s1 & ~s2;
    assign fall = s2 & ~s1;
endmodule

// File: rtl/dacfe_shift.sv
module dacfe_shift
    import dacfe_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sclk,
    input  logic                  fs_n,
    input  logic                  sdi,
    input  logic                  rb_load,
    input  logic [FRAME_BITS-1:0] rb_word,
    output logic                  frame_rise,
    output logic                  frame_valid,
    output logic [FRAME_BITS-1:0] word,
    output logic                  sdo
);
    logic [1:0] e_rise, e_fall;
    logic       sdi_q;
    logic       active;
    logic [CNT_W-1:0] cnt;
    logic [FRAME_BITS-1:0] shreg;

    // bit 1: frame strobe, bit 0: serial clock
    dacfe_sync #(.W(2), .RV(2'b11)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .din  ({fs_n, sclk}),
        .rise (e_rise),
        .fall (e_fall)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sdi_q  <= 1'b0;
            active <= 1'b0;
            cnt    <= '0;
            shreg  <= '0;
            sdo    <= 1'b0;
        end else begin
            sdi_q <= sdi;
            if (e_fall[1]) begin
                active <= 1'b1;
                cnt    <= '0;
                sdo    <= shreg[FRAME_BITS-1];
            end else if (e_rise[1]) begin
                active <= 1'b0;
            end
            if (active && !e_rise[1] && e_fall[0]) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdi_q};
                if (cnt != CNT_W'(FRAME_BITS))
                    cnt <= cnt + 1'b1;
            end else if (active && e_rise[0]) begin
                sdo <= shreg[FRAME_BITS-1];
            end
            if (rb_load)
                shreg <= rb_word;
        end
    end

    assign frame_rise  = e_rise[1] && active;
    assign frame_valid = frame_rise && (cnt == CNT_W'(FRAME_BITS));
    assign word        = shreg;

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(FRAME_BITS)); // R7
endmodule

// File: rtl/dacfe_chan.sv
module dacfe_chan
    import dacfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  clr,
    input  code_t rst_val,
    input  logic  wr_hold,
    input  logic  wr_act,
    input  logic  upd,
    input  logic  sync_ld,
    input  logic  ld_fall,
    input  logic  lmask,
    input  logic  pd_we,
    input  code_t din,
    output code_t hold_o,
    output code_t act_o,
    output logic  pd_o
);
    code_t hold_q, act_q, hold_n, act_n;
    logic  pd_q;

    always_comb begin
        hold_n = wr_hold ? din : hold_q;
        act_n  = act_q;
        if (upd)
            act_n = hold_q;
        if (wr_act)
            act_n = din;
        if (sync_ld && !lmask)
            act_n = din;
        if (ld_fall && !lmask)
            act_n = hold_n;
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            hold_q <= rst_val;
            act_q  <= rst_val;
            pd_q   <= 1'b0;
        end else begin
            hold_q <= hold_n;
            act_q  <= act_n;
            if (pd_we)
                pd_q <= din[0];
        end
    end

    assign hold_o = hold_q;
    assign act_o  = act_q;
    assign pd_o   = pd_q;

    AST_ASYNC_COPY: assert property (@(posedge clk) disable iff (rst)
        (ld_fall && !lmask && !clr) |=> (act_q == hold_q)); // R4
    AST_SYNC_COPY: assert property (@(posedge clk) disable iff (rst)
        (sync_ld && !lmask && !ld_fall && !clr) |=> (act_q == $past(din))); // R5
    AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (rst)
        (!wr_hold && !clr) |=> $stable(hold_q)); // R3
    AST_SOFT_LEVEL: assert property (@(posedge clk) disable iff (rst)
        clr |=> (act_q == $past(rst_val) && hold_q == $past(rst_val) && !pd_q)); // R9
endmodule

// File: rtl/quad_dac_frontend.sv
module quad_dac_frontend
    import dacfe_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             mid_sel,
    input  logic             sclk,
    input  logic             fs_n,
    input  logic             sdi,
    input  logic             upd_n,
    output logic [CH*DW-1:0] code_o,
    output logic [CH-1:0]    pd_o,
    output logic             sdo,
    output logic             sdo_oe
);
    logic                  frame_rise, frame_valid;
    logic [FRAME_BITS-1:0] word, rb_word;
    frame_t                fr;
    logic                  upd_s1, upd_s2, ld_fall, ld_low;
    logic                  daisy_en, rb_active, soft_clr;
    logic [CH-1:0]         lmask;
    code_t                 hold_w [CH];
    code_t                 act_w  [CH];
    logic [CH-1:0]         sel_hot;
    code_t                 sel_code;
    logic                  found;

    dacfe_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .sclk        (sclk),
        .fs_n        (fs_n),
        .sdi         (sdi),
        .rb_load     (frame_valid && fr.cmd == CMD_RDBK),
        .rb_word     (rb_word),
        .frame_rise  (frame_rise),
        .frame_valid (frame_valid),
        .word        (word),
        .sdo         (sdo)
    );

    assign fr = frame_t'(word);

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_s1 <= 1'b1;
            upd_s2 <= 1'b1;
        end else begin
            upd_s1 <= upd_n;
            upd_s2 <= upd_s1;
        end
    end
    assign ld_fall = upd_s2 && !upd_s1;
    assign ld_low  = !upd_s1;

    assign soft_clr = frame_valid && fr.cmd == CMD_SRST;

    always_ff @(posedge clk) begin
        if (rst || soft_clr) begin
            daisy_en  <= 1'b0;
            rb_active <= 1'b0;
            lmask     <= '0;
        end else begin
            if (frame_rise)
                rb_active <= frame_valid && fr.cmd == CMD_RDBK;
            if (frame_valid && fr.cmd == CMD_CHAIN)
                daisy_en <= fr.data[0];
            if (frame_valid && fr.cmd == CMD_LMASK)
                lmask <= fr.data[CH-1:0];
        end
    end

    always_comb begin
        sel_hot  = '0;
        sel_code = '0;
        found    = 1'b0;
        for (int i = 0; i < CH; i++) begin
            if (fr.mask[i] && !found) begin
                found      = 1'b1;
                sel_hot[i] = 1'b1;
                sel_code   = hold_w[i];
            end
        end
    end
    assign rb_word = {CMD_W'(0), sel_hot, sel_code};

    for (genvar g = 0; g < CH; g++) begin : g_ch
        logic hit;
        assign hit = frame_valid && fr.mask[g];
        dacfe_chan u_chan (
            .clk     (clk),
            .rst     (rst),
            .clr     (soft_clr),
            .rst_val (reset_code(mid_sel)),
            .wr_hold (hit && (fr.cmd == CMD_WR || fr.cmd == CMD_WRUPD)),
            .wr_act  (hit && fr.cmd == CMD_WRUPD),
            .upd     (hit && fr.cmd == CMD_UPD),
            .sync_ld (hit && fr.cmd == CMD_WR && ld_low),
            .ld_fall (ld_fall),
            .lmask   (lmask[g]),
            .pd_we   (hit && fr.cmd == CMD_PWR),
            .din     (fr.data),
            .hold_o  (hold_w[g]),
            .act_o   (act_w[g]),
            .pd_o    (pd_o[g])
        );
        assign code_o[g*DW +: DW] = act_w[g];
    end

    assign sdo_oe = daisy_en || rb_active;

    AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (rst)
        (frame_rise && !frame_valid && !ld_fall) |=> ($stable(code_o) && $stable(pd_o))); // R7
    AST_RDBK_ONE_FRAME: assert property (@(posedge clk) disable iff (rst)
        (frame_rise && rb_active && !daisy_en && !(frame_valid && fr.cmd inside {CMD_RDBK, CMD_CHAIN})) |=> !sdo_oe); // R12
endmodule

// File: tb/quad_dac_frontend_test.sv
module quad_dac_frontend_test;
    logic        clk = 1'b0;
    logic        rst, mid_sel, sclk, fs_n, sdi, upd_n;
    logic [63:0] code_o;
    logic [3:0]  pd_o;
    logic        sdo, sdo_oe;

    always #4 clk = ~clk;

    quad_dac_frontend uut (
        .clk(clk), .rst(rst), .mid_sel(mid_sel), .sclk(sclk), .fs_n(fs_n),
        .sdi(sdi), .upd_n(upd_n), .code_o(code_o), .pd_o(pd_o),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    typedef struct {
        int          kind;   // 0 codes, 1 pd flags, 2 output enable, 3 captured serial word
        string       tag;
        logic [63:0] exp;
    } item_t;

    item_t       sb[$];
    int          n_chk  = 0;
    int          n_fail = 0;
    logic [23:0] rx;
    bit          done = 1'b0;

    function automatic logic [63:0] codes(input logic [15:0] c0, c1, c2, c3);
        return {c3, c2, c1, c0};
    endfunction

    function automatic logic [23:0] fw(input logic [3:0] c, input logic [3:0] m, input logic [15:0] d);
        return {c, m, d};
    endfunction

    task automatic push(input int k, input string t, input logic [63:0] e);
        item_t it;
        it.kind = k;
        it.tag  = t;
        it.exp  = e;
        sb.push_back(it);
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic drain;
        while (sb.size() != 0) @(negedge clk);
    endtask

    task automatic send(input logic [23:0] w, input int nb = 24);
        rx   = '0;
        fs_n = 1'b0;
        wclk(6);
        for (int i = 0; i < nb; i++) begin
            sdi = w[23-i];
            wclk(6);
            rx   = {rx[22:0], sdo};
            sclk = 1'b0;
            wclk(6);
            sclk = 1'b1;
        end
        wclk(6);
        fs_n = 1'b1;
        wclk(8);
    endtask

    task automatic pulse_upd;
        upd_n = 1'b0;
        wclk(6);
        upd_n = 1'b1;
        wclk(6);
    endtask

    // monitor: pops expected items and compares with what the design shows
    always @(negedge clk) begin
        if (sb.size() != 0) begin
            item_t       it;
            logic [63:0] act;
            it = sb.pop_front();
            case (it.kind)
                0:       act = code_o;
                1:       act = {60'b0, pd_o};
                2:       act = {63'b0, sdo_oe};
                default: act = {40'b0, rx};
            endcase
            n_chk++;
            if (act !== it.exp) begin
                n_fail++;
                $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hang expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; mid_sel = 1'b1; sclk = 1'b1; fs_n = 1'b1; sdi = 1'b0; upd_n = 1'b1;
        wclk(5);
        rst = 1'b0;
        wclk(4);
        push(0, "R8 midscale after reset", codes(16'h8000, 16'h8000, 16'h8000, 16'h8000));
        push(1, "R8 pd clear after reset", 64'h0);
        push(2, "R8 sdo_oe low after reset", 64'h0);
        drain;

        send(fw(4'd1, 4'b0001, 16'h1111));
        push(0, "R1 write holding keeps active", codes(16'h8000, 16'h8000, 16'h8000, 16'h8000));
        drain;

        send(fw(4'd2, 4'b0001, 16'h0000));
        push(0, "R3 update masked channel", codes(16'h1111, 16'h8000, 16'h8000, 16'h8000));
        drain;

        send(fw(4'd3, 4'b0110, 16'hABCD));
        push(0, "R2 write and update two channels", codes(16'h1111, 16'hABCD, 16'hABCD, 16'h8000));
        drain;

        send(fw(4'd1, 4'b1000, 16'h5555));
        pulse_upd;
        push(0, "R4 async load copies all", codes(16'h1111, 16'hABCD, 16'hABCD, 16'h5555));
        drain;

        send(fw(4'd5, 4'b0000, 16'h0001));
        send(fw(4'd1, 4'b0001, 16'h2222));
        send(fw(4'd1, 4'b0010, 16'h3333));
        pulse_upd;
        push(0, "R6 load mask excludes channel 0", codes(16'h1111, 16'h3333, 16'hABCD, 16'h5555));
        drain;

        send(fw(4'd5, 4'b0000, 16'h0000));
        upd_n = 1'b0;
        wclk(6);
        push(0, "R4 fall after unmask copies channel 0", codes(16'h2222, 16'h3333, 16'hABCD, 16'h5555));
        drain;
        send(fw(4'd1, 4'b0100, 16'h7777));
        push(0, "R5 sync write with strobe low", codes(16'h2222, 16'h3333, 16'h7777, 16'h5555));
        drain;
        upd_n = 1'b1;
        wclk(6);

        send(fw(4'd3, 4'b1111, 16'h0000), 20);
        push(0, "R7 short frame discarded", codes(16'h2222, 16'h3333, 16'h7777, 16'h5555));
        drain;

        send(fw(4'd7, 4'b1111, 16'h0001));
        send(fw(4'd0, 4'b1111, 16'h0001));
        send(fw(4'd12, 4'b1111, 16'h0001));
        push(0, "R13 unassigned commands ignored", codes(16'h2222, 16'h3333, 16'h7777, 16'h5555));
        push(1, "R13 pd untouched", 64'h0);
        drain;

        send(fw(4'd4, 4'b0101, 16'h0001));
        push(1, "R10 power down channels 0 and 2", 64'h5);
        drain;
        send(fw(4'd4, 4'b0001, 16'h0000));
        push(1, "R10 power up channel 0 only", 64'h4);
        drain;

        send(fw(4'd9, 4'b0110, 16'h0000));
        push(2, "R12 sdo_oe high after request", 64'h1);
        drain;
        send(fw(4'd0, 4'b0000, 16'h0000));
        push(3, "R12 readback word", {40'b0, 4'h0, 4'b0010, 16'h3333});
        push(2, "R12 sdo_oe low after readback", 64'h0);
        drain;

        send(fw(4'd8, 4'b0000, 16'h0001));
        push(2, "R11 daisy enables sdo", 64'h1);
        drain;
        send(fw(4'd0, 4'b0000, 16'hBEEF));
        push(3, "R11 chain echoes enable frame", {40'b0, 24'h800001});
        drain;
        send(fw(4'd0, 4'b0000, 16'h1357));
        push(3, "R11 chain echoes previous frame", {40'b0, 24'h00BEEF});
        drain;
        send(fw(4'd8, 4'b0000, 16'h0000));
        push(3, "R11 chain echo before disable", {40'b0, 24'h001357});
        push(2, "R11 sdo_oe low after disable", 64'h0);
        drain;

        mid_sel = 1'b0;
        wclk(2);
        send(fw(4'd6, 4'b0000, 16'h0000));
        push(0, "R9 soft reset to zero", 64'h0);
        push(1, "R9 soft reset clears pd", 64'h0);
        drain;

        send(fw(4'd3, 4'b1111, 16'h4242));
        push(0, "R2 write all channels", codes(16'h4242, 16'h4242, 16'h4242, 16'h4242));
        drain;
        mid_sel = 1'b1;
        rst = 1'b1;
        wclk(3);
        rst = 1'b0;
        wclk(3);
        push(0, "R8 reset back to midscale", codes(16'h8000, 16'h8000, 16'h8000, 16'h8000));
        drain;

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule